// File: doc/BRIEF.md
# Receive PHY Power-Up Sequencer

This block brings a receive PHY up from a held-off condition and takes it back down in a fixed, safe order. On a power-on command it releases the PHY's reset, waits a settle time, and only then releases the PHY's shutdown. From that point it samples the PHY's 4-bit internal state code at a fixed cadence. Power-up counts as complete when the code shows idle (7) or ultra-low-power (8). If neither code is seen before a long timeout expires, the block flags an error and powers the PHY back down.

After the first successful power-up, the block waits a further calibration interval and then looks at a calibration-done flag. If the flag is set, it keeps the 4-bit termination-calibration result. That result is then held until reset, and later power-ups skip the interval entirely. Two force-receive-mode control bits are driven high from the command until readiness and are cleared once the PHY is ready.

A power-off command, at any point before or after readiness, runs the reverse order. Shutdown is asserted first, then reset one cycle later, and then a one-cycle request returns the PHY's test interface to state-machine access and resets it. All timing is derived from a clock-frequency parameter (in MHz) and microsecond parameters. All control and status pins are plain level or pulse signals with no handshake.

Top module: `phy_pwr_sequencer`

## Requirements
- R1: After a power-on command is accepted, reset is released (phy_reset_n high) on the next clock edge, and shutdown is released (phy_shutdown_n high) exactly SETTLE cycles later, where SETTLE = CLK_MHZ * SETTLE_US.
- R2: phy_shutdown_n is never high while phy_reset_n is low.
- R3: Power-up completes (seq_done high) only when a sampled state code equals 7 (idle) or 8 (ultra-low-power). Every other code value in 0..15 keeps the block polling.
- R4: If no ready code is sampled within TIMEOUT = CLK_MHZ * TIMEOUT_US cycles of shutdown release, seq_error rises and shutdown is driven low in the same cycle, followed by the power-down order of R6.
- R5: The state code is sampled only once every POLL_CYCLES clocks. The first sample is taken POLL_CYCLES cycles after shutdown release. A ready code that is present only between samples has no effect.
- R6: Power-down order: phy_shutdown_n falls first, phy_reset_n falls one cycle later, and tif_reset_req is high for exactly the following cycle. After that the block is off.
- R7: On the first successful power-up, seq_done rises CAL_WAIT = CLK_MHZ * CAL_WAIT_US cycles plus one after readiness. If cal_done is high at the check, cal_value is latched to cal_code and cal_held goes high.
- R8: If cal_done is low at the check, nothing is latched, and the next power-up waits and checks again.
- R9: Once cal_held is high, later power-ups set seq_done in the same cycle readiness is sampled. cal_code never changes again until reset.
- R10: force_rx_mode is 2'b11 from the cycle reset is released until readiness, and 2'b00 in every other state.
- R11: A power-off command during settle, polling or calibration wait aborts and starts the R6 order on the next edge. A power-on command while powered up is ignored. A power-on and power-off command in the same cycle while off keep the block off.
- R12: A ready code on the sample that coincides with timeout expiry counts as success, with no error. A power-off command in the same cycle as a ready sample wins, and power-down follows with no seq_done and no calibration capture.
- R13: After reset all outputs are low. seq_error stays high through power-down and while off, and it clears when the next power-on command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Power-on command, sampled while off |
| pwr_off_req | input | 1 | Power-off command, has priority over power-on |
| phy_state_code | input | 4 | PHY internal state code |
| cal_done | input | 1 | Termination calibration finished flag |
| cal_value | input | 4 | Termination calibration result |
| phy_reset_n | output | 1 | PHY reset control, high = released |
| phy_shutdown_n | output | 1 | PHY shutdown control, high = released |
| force_rx_mode | output | 2 | Force-receive-mode control bits |
| tif_reset_req | output | 1 | One-cycle test-interface return-and-reset request |
| seq_done | output | 1 | PHY powered up and ready |
| seq_error | output | 1 | Power-up timed out |
| cal_held | output | 1 | A calibration value has been captured |
| cal_code | output | 4 | Captured calibration value |

## Verification
Two pairs of events can land on the same clock edge. The first is the last poll sample and the timeout expiry: the bench places a ready code exactly on the sample that falls on the timeout cycle and expects success with no error. The second is a ready sample and a power-off command: the bench raises power-off in the cycle before a ready sample and expects shutdown to drop at that sample, with no seq_done and no calibration capture. The remaining runs put ready codes on random sample indices, with single-cycle ready glitches between samples, and the expected completion cycle for each run is derived from the settle, poll and calibration intervals.

// File: rtl/pseq_pkg.sv
`timescale 1ns/1ps
package pseq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_SETTLE,
    ST_POLL,
    ST_CALWAIT,
    ST_CALCHK,
    ST_ON,
    ST_DN_SHUT,
    ST_DN_RST,
    ST_DN_TIF
  } seq_state_e;

  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_IDLE = 4'd7;
  localparam logic [CODE_W-1:0] CODE_ULP  = 4'd8;

  function automatic logic code_is_ready(input logic [CODE_W-1:0] code);
    return (code == CODE_IDLE) || (code == CODE_ULP);
  endfunction

endpackage

// File: rtl/pseq_timer.sv
`timescale 1ns/1ps
module pseq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt_q;

  assign hit = en && !clr && (cnt_q == (limit - W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr || hit) cnt_q <= '0;
    else if (en)        cnt_q <= cnt_q + W'(1);
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && limit != '0) |-> (cnt_q < limit));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q == '0));

endmodule

// File: rtl/pseq_poll_unit.sv
`timescale 1ns/1ps
module pseq_poll_unit
  import pseq_pkg::*;
#(
  parameter int unsigned       POLL_CYCLES = 16,
  parameter longint unsigned   TIMEOUT_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [CODE_W-1:0] phy_code,
  output logic              ready_seen,
  output logic              timeout_hit
);

  localparam int unsigned PW = $clog2(POLL_CYCLES + 1);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

  logic poll_tick;

  pseq_timer #(.W(PW)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!active),
    .en    (active),
    .limit (PW'(POLL_CYCLES)),
    .hit   (poll_tick)
  );

  pseq_timer #(.W(TW)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!active),
    .en    (active),
    .limit (TW'(TIMEOUT_CYC)),
    .hit   (timeout_hit)
  );

  assign ready_seen = poll_tick && code_is_ready(phy_code);

  // R4
  tmo_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |-> $past(active));

endmodule

// File: rtl/pseq_cal_capture.sv
`timescale 1ns/1ps
module pseq_cal_capture #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          cal_done,
  input  logic [CW-1:0] cal_value,
  output logic          held,
  output logic [CW-1:0] code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      code <= '0;
    end else if (capture && cal_done && !held) begin
      held <= 1'b1;
      code <= cal_value;
    end
  end

  // R9
  held_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> held);

  // R9
  code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable(code));

  // R8
  no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !cal_done && !held) |=> !held);

endmodule

// File: rtl/phy_pwr_sequencer.sv
`timescale 1ns/1ps
module phy_pwr_sequencer
  import pseq_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned SETTLE_US   = 10,
  parameter int unsigned POLL_CYCLES = 2500,
  parameter int unsigned TIMEOUT_US  = 5000000,
  parameter int unsigned CAL_WAIT_US = 100,
  parameter int unsigned CAL_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on_req,
  input  logic             pwr_off_req,
  input  logic [3:0]       phy_state_code,
  input  logic             cal_done,
  input  logic [CAL_W-1:0] cal_value,
  output logic             phy_reset_n,
  output logic             phy_shutdown_n,
  output logic [1:0]       force_rx_mode,
  output logic             tif_reset_req,
  output logic             seq_done,
  output logic             seq_error,
  output logic             cal_held,
  output logic [CAL_W-1:0] cal_code
);

  localparam longint unsigned SETTLE_CYC  = 64'(CLK_MHZ) * 64'(SETTLE_US);
  localparam longint unsigned CAL_CYC     = 64'(CLK_MHZ) * 64'(CAL_WAIT_US);
  localparam longint unsigned TIMEOUT_CYC = 64'(CLK_MHZ) * 64'(TIMEOUT_US);
  localparam longint unsigned DLY_MAX     = (SETTLE_CYC > CAL_CYC) ? SETTLE_CYC : CAL_CYC;
  localparam int unsigned     DW          = $clog2(DLY_MAX + 1);

  seq_state_e st_q, st_d;
  logic       err_q;
  logic       err_set, err_clr;
  logic       busy;
  logic       dly_en, dly_hit;
  logic [DW-1:0] dly_limit;
  logic       poll_active, ready_seen, timeout_hit;

  // shared settle / calibration-wait delay counter
  assign dly_en    = (st_q == ST_SETTLE) || (st_q == ST_CALWAIT);
  assign dly_limit = (st_q == ST_SETTLE) ? DW'(SETTLE_CYC) : DW'(CAL_CYC);

  pseq_timer #(.W(DW)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!dly_en),
    .en    (dly_en),
    .limit (dly_limit),
    .hit   (dly_hit)
  );

  assign poll_active = (st_q == ST_POLL);

  pseq_poll_unit #(
    .POLL_CYCLES (POLL_CYCLES),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_poll (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (poll_active),
    .phy_code    (phy_state_code),
    .ready_seen  (ready_seen),
    .timeout_hit (timeout_hit)
  );

  pseq_cal_capture #(.CW(CAL_W)) u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (st_q == ST_CALCHK),
    .cal_done  (cal_done),
    .cal_value (cal_value),
    .held      (cal_held),
    .code      (cal_code)
  );

  assign busy = (st_q == ST_SETTLE) || (st_q == ST_POLL) ||
                (st_q == ST_CALWAIT) || (st_q == ST_CALCHK);

  always_comb begin
    st_d    = st_q;
    err_set = 1'b0;
    err_clr = 1'b0;
    unique case (st_q)
      ST_OFF: begin
        if (pwr_on_req && !pwr_off_req) begin
          st_d    = ST_SETTLE;
          err_clr = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (pwr_off_req)  st_d = ST_DN_SHUT;
        else if (dly_hit) st_d = ST_POLL;
      end
      ST_POLL: begin
        if (pwr_off_req)     st_d = ST_DN_SHUT;
        else if (ready_seen) st_d = cal_held ? ST_ON : ST_CALWAIT;
        else if (timeout_hit) begin
          st_d    = ST_DN_SHUT;
          err_set = 1'b1;
        end
      end
      ST_CALWAIT: begin
        if (pwr_off_req)  st_d = ST_DN_SHUT;
        else if (dly_hit) st_d = ST_CALCHK;
      end
      ST_CALCHK:  st_d = pwr_off_req ? ST_DN_SHUT : ST_ON;
      ST_ON:      if (pwr_off_req) st_d = ST_DN_SHUT;
      ST_DN_SHUT: st_d = ST_DN_RST;
      ST_DN_RST:  st_d = ST_DN_TIF;
      ST_DN_TIF:  st_d = ST_OFF;
      default:    st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  // output decode
  always_comb begin
    phy_reset_n    = 1'b0;
    phy_shutdown_n = 1'b0;
    unique case (st_q)
      ST_SETTLE, ST_DN_SHUT: phy_reset_n = 1'b1;
      ST_POLL, ST_CALWAIT, ST_CALCHK, ST_ON: begin
        phy_reset_n    = 1'b1;
        phy_shutdown_n = 1'b1;
      end
      default: ;
    endcase
  end

  assign force_rx_mode = ((st_q == ST_SETTLE) || (st_q == ST_POLL)) ? 2'b11 : 2'b00;
  assign tif_reset_req = (st_q == ST_DN_TIF);
  assign seq_done      = (st_q == ST_ON);
  assign seq_error     = err_q;

  // R2
  rel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_shutdown_n) |-> $past(phy_reset_n));

  // R6
  dn_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_reset_n) |-> (!phy_shutdown_n && $past(!phy_shutdown_n)));

  // R4
  err_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_error) |-> !phy_shutdown_n);

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pwr_off_req) |=> (st_q == ST_DN_SHUT));

  // R9
  skip_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_active && ready_seen && cal_held && !pwr_off_req) |=> seq_done);

  // R6
  tif_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tif_reset_req |=> !tif_reset_req);

endmodule

// File: tb/phy_pwr_sequencer_tb_top.sv
`timescale 1ns/1ps
module phy_pwr_sequencer_tb_top;

  localparam int SET = 8;
  localparam int PC  = 4;
  localparam int TMO = 64;
  localparam int CW  = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_on_req = 1'b0;
  logic       pwr_off_req = 1'b0;
  logic [3:0] phy_state_code = 4'd0;
  logic       cal_done = 1'b0;
  logic [3:0] cal_value = 4'd0;
  logic       phy_reset_n, phy_shutdown_n, tif_reset_req, seq_done, seq_error, cal_held;
  logic [1:0] force_rx_mode;
  logic [3:0] cal_code;

  int total = 0;
  int fails = 0;
  bit m_held = 0;
  logic [3:0] m_code = 4'd0;

  always #2 clk = ~clk;

  phy_pwr_sequencer #(
    .CLK_MHZ(1), .SETTLE_US(SET), .POLL_CYCLES(PC),
    .TIMEOUT_US(TMO), .CAL_WAIT_US(CW), .CAL_W(4)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .phy_state_code(phy_state_code), .cal_done(cal_done), .cal_value(cal_value),
    .phy_reset_n(phy_reset_n), .phy_shutdown_n(phy_shutdown_n),
    .force_rx_mode(force_rx_mode), .tif_reset_req(tif_reset_req),
    .seq_done(seq_done), .seq_error(seq_error), .cal_held(cal_held), .cal_code(cal_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nonready();
    logic [3:0] v;
    do v = 4'($urandom % 16); while (v == 4'd7 || v == 4'd8);
    return v;
  endfunction

  function automatic int exp_done_at(input int k, input bit held);
    return SET + PC * k + (held ? 0 : CW + 1);
  endfunction

  task automatic fire_on();
    @(negedge clk); pwr_on_req = 1'b1;
    @(negedge clk); pwr_on_req = 1'b0;
  endtask

  task automatic run_up(input int k, input bit cd, input logic [3:0] cv,
                        input bit glitch, input bit off_at_ready);
    int ed, fd, rn;
    logic [3:0] rc;
    rc = ($urandom % 2) ? 4'd7 : 4'd8;
    rn = SET + PC * k - 2;
    ed = exp_done_at(k, m_held);
    cal_done = cd; cal_value = cv; phy_state_code = nonready();
    fire_on();
    chk(phy_reset_n && !phy_shutdown_n, "R1 rst first", phy_shutdown_n, 0);
    chk(force_rx_mode == 2'b11, "R10 set", force_rx_mode, 3);
    chk(!seq_error, "R13 err clear", seq_error, 0);
    fd = -1;
    for (int n = 0; n < ed + 3; n++) begin
      if (n == SET - 1) chk(phy_reset_n && !phy_shutdown_n, "R2", phy_shutdown_n, 0);
      if (n == SET) chk(phy_shutdown_n, "R1 settle", phy_shutdown_n, 1);
      if (n == SET + PC * k - 1) chk(force_rx_mode == 2'b11, "R10 poll", force_rx_mode, 3);
      if (n == SET + PC * k) begin
        if (off_at_ready)
          chk(!phy_shutdown_n && phy_reset_n && !seq_done, "R12 off wins", phy_shutdown_n, 0);
        else
          chk(force_rx_mode == 2'b00, "R10 clear", force_rx_mode, 0);
      end
      if (seq_done && fd < 0) fd = n;
      if (n == rn) phy_state_code = rc;
      else if (n < rn) phy_state_code = (glitch && k >= 2 && n == rn - 4) ? rc : nonready();
      if (off_at_ready) pwr_off_req = (n == rn + 1);
      @(negedge clk);
    end
    if (off_at_ready) begin
      chk(fd < 0, "R12 no done", fd, -1);
      chk(cal_held == m_held, "R12 no capture", cal_held, m_held);
    end else begin
      chk(fd == ed, m_held ? "R9 R3 R5 timing" : "R7 R3 R5 timing", fd, ed);
      if (!m_held && cd) begin m_held = 1; m_code = cv; end
      chk(cal_held == m_held, m_held ? "R7 held" : "R8 none", cal_held, m_held);
      chk(cal_code == m_code, "R9 code", cal_code, m_code);
    end
  endtask

  task automatic run_down();
    @(negedge clk); pwr_off_req = 1'b1;
    @(negedge clk); pwr_off_req = 1'b0;
    chk(!phy_shutdown_n && phy_reset_n && !seq_done, "R6 shut first", phy_reset_n, 1);
    @(negedge clk);
    chk(!phy_reset_n && !tif_reset_req, "R6 rst second", phy_reset_n, 0);
    @(negedge clk);
    chk(tif_reset_req, "R6 tif pulse", tif_reset_req, 1);
    @(negedge clk);
    chk(!tif_reset_req && !phy_reset_n, "R6 off", tif_reset_req, 0);
    chk(cal_code == m_code, "R9 kept", cal_code, m_code);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({phy_reset_n, phy_shutdown_n, force_rx_mode, tif_reset_req, seq_done, seq_error, cal_held} == 8'd0,
        "R13 reset", {phy_reset_n, phy_shutdown_n, seq_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_up(3, 1'b0, 4'h5, 1'b0, 1'b0);   // R8: no capture
    run_down();
    run_up(2, 1'b1, 4'hA, 1'b1, 1'b0);   // R7 capture, R5 glitch ignored
    run_down();
    run_up(4, 1'b1, 4'h3, 1'b1, 1'b0);   // R9 no wait, no overwrite
    // R11: power-on while up ignored
    fire_on();
    repeat (2) @(negedge clk);
    chk(seq_done && phy_shutdown_n, "R11 on ignored", seq_done, 1);
    run_down();

    // R4: timeout path
    phy_state_code = nonready();
    fire_on();
    for (int n = 0; n < 77; n++) begin
      if (n == SET + TMO - 1) chk(!seq_error && phy_shutdown_n, "R4 pre", seq_error, 0);
      if (n == SET + TMO) chk(seq_error && !phy_shutdown_n && phy_reset_n, "R4 err", seq_error, 1);
      if (n == SET + TMO + 1) chk(!phy_reset_n, "R4 rst", phy_reset_n, 0);
      if (n == SET + TMO + 2) chk(tif_reset_req, "R4 R6 tif", tif_reset_req, 1);
      phy_state_code = nonready();
      @(negedge clk);
    end
    chk(seq_error && !seq_done && !phy_reset_n, "R13 err held", seq_error, 1);

    // R12: ready on the sample that meets the timeout
    run_up(TMO / PC, 1'b1, 4'h1, 1'b0, 1'b0);
    chk(!seq_error, "R12 tmo tie", seq_error, 0);
    run_down();

    // R11: abort during polling
    phy_state_code = nonready();
    fire_on();
    for (int n = 0; n < 15; n++) begin
      pwr_off_req = (n == SET + 1);
      if (n == SET + 2) chk(!phy_shutdown_n && phy_reset_n, "R11 abort", phy_shutdown_n, 0);
      if (n == SET + 3) chk(!phy_reset_n, "R11 abort rst", phy_reset_n, 0);
      if (n == SET + 4) chk(tif_reset_req, "R11 abort tif", tif_reset_req, 1);
      chk(!seq_done, "R11 no done", seq_done, 0);
      @(negedge clk);
    end

    // R12: power-off on the ready sample
    run_up(5, 1'b1, 4'h9, 1'b0, 1'b1);

    // R11: on and off together while off
    @(negedge clk); pwr_on_req = 1'b1; pwr_off_req = 1'b1;
    @(negedge clk); pwr_on_req = 1'b0; pwr_off_req = 1'b0;
    repeat (3) begin
      chk(!phy_reset_n && !phy_shutdown_n, "R11 off wins", phy_reset_n, 0);
      @(negedge clk);
    end

    for (int i = 0; i < 10; i++) begin
      run_up(1 + int'($urandom % 15), 1'($urandom % 2), 4'($urandom % 16), 1'($urandom % 2), 1'b0);
      run_down();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

endmodule